// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of a bus-master network controller. The host builds a ring of transmit descriptors in shared memory. It hands each descriptor to the device by setting an ownership flag, then strobes a poll-demand input. The engine walks the ring from its current position. For every descriptor the device owns, it reads the referenced buffer and sends its bytes out as a byte stream. It then writes a completion status back into the descriptor, which also returns the descriptor to the host, and moves on to the next entry. It stops and waits for the next poll demand when it meets an entry that the host still owns.

Frames may span several descriptors, delimited by first-segment and last-segment flags. The engine tracks this sequence and reports a broken sequence through an error-summary bit in the written-back status. A descriptor flagged as a setup packet is read in full at a fixed size but is consumed internally and never reaches the byte stream. Its completion status is a distinct code. A run-enable input gates all activity.

Top module: `txr_engine`

## Requirements
- R1: After a synchronous reset the engine is suspended at ring position 0. The byte-stream valid, the last-byte flag and both memory strobes are low, and the first accepted poll fetches the status word at `ring_base`.
- R2: A descriptor is four consecutive memory words at `ring_base + 4*index`: status (word 0), control (word 1) and buffer word address (word 2). If status bit 31 is 0 (host-owned), the engine suspends and makes no write and no byte. Each later poll re-reads the same status word.
- R3: While `tx_run` is low, a poll demand has no effect: no memory access and no byte output.
- R4: For an owned data descriptor, the engine sends exactly the number of bytes in control bits 10:0. The bytes come from consecutive words starting at the buffer address, least significant byte of each word first.
- R5: A frame runs from a descriptor with control bit 29 (first segment) to one with control bit 30 (last segment). `tx_last` is high with the final byte of a last-segment descriptor and at no other time.
- R6: On completion the engine writes the descriptor's status word with bit 31 cleared. A correctly sequenced data descriptor gets 0x00000000.
- R7: Sequence mismatch is a first-segment flag while a frame is open, or a missing first-segment flag while no frame is open. On a mismatch the descriptor's bytes are not sent, status 0x00008000 (bit 15, error summary) is written, and the frame is closed.
- R8: A descriptor with control bit 27 (setup) has its 192 buffer bytes read and none output, whatever its length field holds. Its status is written as 0x7FFFFFFF, and it leaves the open/closed frame state unchanged.
- R9: After a write-back the engine goes on without a new poll to index+1, or to index 0 when control bit 25 (end of ring) was set.
- R10: A memory read and a memory write are never issued in the same cycle, and every write clears bit 31 and carries one of the three status codes.
- R11: `tx_run` is sampled between descriptors. If it is low after a write-back, the engine suspends at the next index without fetching it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of descriptor 0 |
| poll_demand | input | 1 | One-cycle strobe: resume ring processing |
| tx_run | input | 1 | Transmission enable |
| mem_rd | output | 1 | Memory read strobe; data on `mem_rdata` two cycles later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data (descriptor status) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte-stream valid |
| tx_data | output | 8 | Byte-stream data |
| tx_last | output | 1 | Final byte of a frame |

## Verification
Buffer lengths 1 through 12 are swept one at a time. This covers every alignment of the final partial word and shows whether the byte count, the byte order and the read count track the length field. A three-descriptor chain, once with a setup packet in the middle, tells correct frame continuation apart from a reset of the frame state. Mismatch patterns (a missing first flag, and a repeated first flag) separate error handling from ordinary transmission, and a clean frame after them proves the frame was closed. Host-owned entries, a run-enable drop mid-chain and a poll with the enable low tell apart suspend, stop and ignore.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT = 31;
  localparam int LS_BIT  = 30;
  localparam int FS_BIT  = 29;
  localparam int SET_BIT = 27;
  localparam int EOR_BIT = 25;
  localparam int ES_BIT  = 15;

  localparam logic [31:0] STAT_OK    = 32'h0000_0000;
  localparam logic [31:0] STAT_ERR   = 32'h0000_8000;
  localparam logic [31:0] STAT_SETUP = 32'h7FFF_FFFF;

  typedef enum logic [2:0] {
    ST_SUSP, ST_OWN, ST_CTL, ST_BUF, ST_DAT, ST_SEND, ST_WB, ST_ADV
  } txr_state_e;
endpackage

// File: rtl/txr_frame_seq.sv
module txr_frame_seq (
  input  logic clk,
  input  logic rst,
  input  logic chk,
  input  logic fs,
  input  logic ls,
  output logic err
);
  logic in_frame;

  // first-segment flag must appear exactly when no frame is open
  assign err = (fs == in_frame);

  always_ff @(posedge clk) begin
    if (rst) in_frame <= 1'b0;
    else if (chk) in_frame <= err ? 1'b0 : !ls;
  end

  // R7: a mismatch always leaves the frame closed
  a_r7_closed_after_err: assert property (@(posedge clk) disable iff (rst)
    (chk && err) |=> !in_frame);
endmodule

// File: rtl/txr_byte_unpack.sv
module txr_byte_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nbytes,
  input  logic        last_in,
  output logic        busy,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);
  logic [31:0] sh;
  logic [2:0]  cnt;
  logic        lastf;

  assign busy = (cnt != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; cnt <= '0; lastf <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else if (load) begin
      sh <= word; cnt <= nbytes; lastf <= last_in;
      out_valid <= 1'b0; out_last <= 1'b0;
    end else if (cnt != 3'd0) begin
      out_valid <= 1'b1;
      out_data  <= sh[7:0];
      sh        <= sh >> 8;
      cnt       <= cnt - 3'd1;
      out_last  <= lastf && (cnt == 3'd1);
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // R5: last flag only travels with a valid byte
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R4: a new word is loaded only once the previous one is drained
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int IDX_W       = 4,
  parameter int LEN_W       = 11,
  parameter int SETUP_BYTES = 192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          poll_demand,
  input  logic          tx_run,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  localparam logic [LEN_W-1:0] SETUP_LEN = LEN_W'(SETUP_BYTES);
  localparam logic [LEN_W-1:0] WORD_B    = LEN_W'(4);

  txr_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [1:0]       rd_stage;
  logic             d_ls, d_setup, d_eor, d_err;
  logic [LEN_W-1:0] rem, rem_n;
  logic [AW-1:0]    wptr, desc_base, rd_addr;
  logic [2:0]       take;
  logic             captured, seq_chk, seq_err, ub_load, ub_busy;
  logic             unused_rdata;

  assign unused_rdata = ^mem_rdata;

  always_comb begin
    desc_base = ring_base + AW'({idx, 2'b00});
    case (state)
      ST_OWN:  rd_addr = desc_base;
      ST_CTL:  rd_addr = desc_base + AW'(1);
      ST_BUF:  rd_addr = desc_base + AW'(2);
      default: rd_addr = wptr;
    endcase
    captured = (rd_stage == 2'd2);
    take     = (rem >= WORD_B) ? 3'd4 : rem[2:0];
    rem_n    = rem - LEN_W'(take);
    seq_chk  = (state == ST_CTL) && captured && !mem_rdata[SET_BIT];
    ub_load  = (state == ST_DAT) && captured && !d_setup;
  end

  txr_frame_seq u_seq (
    .clk(clk), .rst(rst), .chk(seq_chk),
    .fs(mem_rdata[FS_BIT]), .ls(mem_rdata[LS_BIT]), .err(seq_err)
  );

  txr_byte_unpack u_unpack (
    .clk(clk), .rst(rst), .load(ub_load), .word(mem_rdata), .nbytes(take),
    .last_in(d_ls && (rem_n == '0)), .busy(ub_busy),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SUSP; idx <= '0; rd_stage <= '0;
      d_ls <= 1'b0; d_setup <= 1'b0; d_eor <= 1'b0; d_err <= 1'b0;
      rem <= '0; wptr <= '0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      case (state)
        ST_SUSP: if (poll_demand && tx_run) state <= ST_OWN;
        ST_OWN, ST_CTL, ST_BUF, ST_DAT: begin
          case (rd_stage)
            2'd0: begin mem_rd <= 1'b1; mem_addr <= rd_addr; rd_stage <= 2'd1; end
            2'd1: begin mem_rd <= 1'b0; rd_stage <= 2'd2; end
            default: begin
              rd_stage <= 2'd0;
              case (state)
                ST_OWN: state <= mem_rdata[OWN_BIT] ? ST_CTL : ST_SUSP;
                ST_CTL: begin
                  d_ls    <= mem_rdata[LS_BIT];
                  d_setup <= mem_rdata[SET_BIT];
                  d_eor   <= mem_rdata[EOR_BIT];
                  rem     <= mem_rdata[SET_BIT] ? SETUP_LEN : mem_rdata[LEN_W-1:0];
                  d_err   <= !mem_rdata[SET_BIT] && seq_err;
                  state   <= ST_BUF;
                end
                ST_BUF: begin
                  wptr  <= mem_rdata[AW-1:0];
                  state <= (d_err || rem == '0) ? ST_WB : ST_DAT;
                end
                default: begin
                  wptr  <= wptr + AW'(1);
                  rem   <= rem_n;
                  state <= !d_setup ? ST_SEND : ((rem_n == '0) ? ST_WB : ST_DAT);
                end
              endcase
            end
          endcase
        end
        ST_SEND: if (!ub_busy) state <= (rem == '0) ? ST_WB : ST_DAT;
        ST_WB: begin
          mem_wr    <= 1'b1;
          mem_addr  <= desc_base;
          mem_wdata <= d_setup ? STAT_SETUP : (d_err ? STAT_ERR : STAT_OK);
          state     <= ST_ADV;
        end
        default: begin
          mem_wr <= 1'b0;
          idx    <= d_eor ? '0 : idx + IDX_W'(1);
          state  <= tx_run ? ST_OWN : ST_SUSP;
        end
      endcase
    end
  end

  // R10: reads and writes never overlap
  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R6: every write-back hands ownership back to the host
  a_r6_own_released: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !mem_wdata[OWN_BIT]);
  // R10: only the three status codes are ever written
  a_r10_status_code: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == STAT_OK || mem_wdata == STAT_ERR || mem_wdata == STAT_SETUP));
  // R3: a suspended engine with run low issues no read
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && !tx_run) |=> !mem_rd);
  // R8: a setup packet puts nothing on the byte stream
  a_r8_setup_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DAT && d_setup) |-> !tx_valid);
endmodule

// File: tb/tb_txr_engine.sv
module tb_txr_engine;
  localparam int AW = 8;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic poll_demand = 1'b0, tx_run = 1'b0;
  logic mem_rd, mem_wr, tx_valid, tx_last;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  txr_engine #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .ring_base(ring_base), .poll_demand(poll_demand),
    .tx_run(tx_run), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  // memory model with a host write port
  logic [31:0] mem [0:255];
  logic h_we = 1'b0;
  logic [AW-1:0] h_a = '0;
  logic [31:0] h_d = '0;
  always @(posedge clk) begin
    if (h_we) mem[h_a] <= h_d;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // monitor
  int rd_cnt = 0, wr_cnt = 0, nb = 0;
  logic [7:0] rxb [0:255];
  logic       rxl [0:255];
  always @(negedge clk) begin
    if (mem_rd) rd_cnt++;
    if (mem_wr) wr_cnt++;
    if (tx_valid && nb < 256) begin rxb[nb] = tx_data; rxl[nb] = tx_last; nb++; end
  end

  int ncheck = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] eb [0:255];
  int ne = 0;
  int rd0 = 0, wr0 = 0, nb0 = 0;

  function automatic logic [7:0] pat(input int x);
    return 8'((x * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input int a, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_a = AW'(a); h_d = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic wdesc(input int i, input bit own, input bit fs, input bit ls,
                       input bit set, input bit eor, input int len, input int bufw);
    hwr(BASE + 4*i, {own, 31'd0});
    hwr(BASE + 4*i + 1, {1'b0, ls, fs, 1'b0, set, 1'b0, eor, 14'd0, 11'(len)});
    hwr(BASE + 4*i + 2, 32'(bufw));
  endtask

  task automatic mark();
    rd0 = rd_cnt; wr0 = wr_cnt; nb0 = nb; ne = 0;
  endtask

  task automatic exp_add(input int bufw, input int len);
    for (int k = 0; k < len; k++) begin eb[ne] = pat(bufw*4 + k); ne++; end
  endtask

  task automatic poll_wait(input int n);
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // byte count, byte values and last-flag placement against eb[0:ne-1]
  task automatic chk_stream(input string tag, input int frames);
    int bad, lasts;
    bad = -1; lasts = 0;
    chk(nb - nb0 == ne, {tag, " byte count"}, 32'(nb - nb0), 32'(ne));
    for (int k = 0; k < ne && k < nb - nb0; k++) begin
      if (bad < 0 && rxb[nb0+k] !== eb[k]) bad = k;
      if (rxl[nb0+k]) lasts++;
    end
    chk(bad < 0, {tag, " byte values"}, (bad < 0) ? 0 : 32'(rxb[nb0+bad]), (bad < 0) ? 0 : 32'(eb[bad]));
    chk(lasts == frames && (frames == 0 || (ne > 0 && rxl[nb0+ne-1] === 1'b1)),
        {tag, " last flag"}, 32'(lasts), 32'(frames));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; ncheck++;
      $display("FAIL watchdog (R1..R11 run) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!tx_valid && !tx_last, "R1 stream idle", {30'd0, tx_valid, tx_last}, 0);
    chk(!mem_rd && !mem_wr, "R1 memory idle", {30'd0, mem_rd, mem_wr}, 0);

    for (int a = BASE; a < BASE + 64; a++) hwr(a, 32'd0);
    for (int w = 128; w < 240; w++)
      hwr(w, {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)});

    // R3: poll ignored with run low
    wdesc(0, 1, 1, 1, 0, 1, 4, 128);
    mark(); poll_wait(60);
    chk(rd_cnt - rd0 == 0, "R3 no read when stopped", 32'(rd_cnt - rd0), 0);
    chk(nb - nb0 == 0, "R3 no bytes when stopped", 32'(nb - nb0), 0);
    chk(mem[BASE] == 32'h8000_0000, "R3 descriptor untouched", mem[BASE], 32'h8000_0000);

    tx_run = 1'b1;
    // R2: host-owned entry suspends; re-polled each time
    hwr(BASE, 32'd0);
    for (int p = 0; p < 2; p++) begin
      mark(); poll_wait(40);
      chk(rd_cnt - rd0 == 1, "R2 host-owned single fetch", 32'(rd_cnt - rd0), 1);
      chk(wr_cnt - wr0 == 0 && nb == nb0, "R2 host-owned no write/bytes", 32'(wr_cnt - wr0), 0);
    end

    // R4 R1 R6 R9: length sweep, single-descriptor frames, end of ring at index 0
    for (int len = 1; len <= 12; len++) begin
      wdesc(0, 1, 1, 1, 0, 1, len, 128);
      mark(); exp_add(128, len); poll_wait(120);
      chk_stream($sformatf("R4 len %0d", len), 1);
      chk(mem[BASE] == 32'h0, $sformatf("R6 status len %0d", len), mem[BASE], 0);
      chk(rd_cnt - rd0 == 4 + (len + 3) / 4, $sformatf("R9 reads len %0d", len),
          32'(rd_cnt - rd0), 32'(4 + (len + 3) / 4));
    end

    // R5 R9: three-descriptor frame
    wdesc(0, 1, 1, 0, 0, 0, 5, 128);
    wdesc(1, 1, 0, 0, 0, 0, 3, 144);
    wdesc(2, 1, 0, 1, 0, 1, 6, 160);
    mark(); exp_add(128, 5); exp_add(144, 3); exp_add(160, 6); poll_wait(200);
    chk_stream("R5 chained frame", 1);
    chk(rd_cnt - rd0 == 15, "R9 chain reads and wrap", 32'(rd_cnt - rd0), 15);
    chk(mem[BASE] == 0 && mem[BASE+4] == 0 && mem[BASE+8] == 0, "R6 chain statuses",
        mem[BASE+4], 0);

    // R7: missing first-segment flag
    wdesc(0, 1, 0, 1, 0, 1, 4, 128);
    mark(); poll_wait(80);
    chk(nb == nb0, "R7 no-first dropped", 32'(nb - nb0), 0);
    chk(mem[BASE] == 32'h8000, "R7 no-first status", mem[BASE], 32'h8000);
    chk(rd_cnt - rd0 == 4, "R7 no buffer reads", 32'(rd_cnt - rd0), 4);
    // R7: repeated first-segment flag
    wdesc(0, 1, 1, 0, 0, 0, 4, 128);
    wdesc(1, 1, 1, 1, 0, 1, 2, 144);
    mark(); exp_add(128, 4); poll_wait(120);
    chk_stream("R7 open frame part", 0);
    chk(mem[BASE] == 0, "R7 first part status", mem[BASE], 0);
    chk(mem[BASE+4] == 32'h8000, "R7 repeated-first status", mem[BASE+4], 32'h8000);
    chk(rd_cnt - rd0 == 8, "R7 repeated-first reads", 32'(rd_cnt - rd0), 8);
    // R7: frame closed after mismatch
    wdesc(0, 1, 1, 1, 0, 1, 3, 160);
    mark(); exp_add(160, 3); poll_wait(80);
    chk_stream("R7 frame closed after error", 1);
    chk(mem[BASE] == 0, "R7 clean status", mem[BASE], 0);

    // R8: setup packet alone, length field ignored
    wdesc(0, 1, 0, 0, 1, 1, 5, 192);
    mark(); poll_wait(300);
    chk(nb == nb0, "R8 setup emits nothing", 32'(nb - nb0), 0);
    chk(mem[BASE] == 32'h7FFF_FFFF, "R8 setup status", mem[BASE], 32'h7FFF_FFFF);
    chk(rd_cnt - rd0 == 52, "R8 setup reads 192 bytes", 32'(rd_cnt - rd0), 52);
    // R8: setup in the middle of an open frame
    wdesc(0, 1, 1, 0, 0, 0, 2, 128);
    wdesc(1, 1, 0, 0, 1, 0, 0, 192);
    wdesc(2, 1, 0, 1, 0, 1, 2, 144);
    mark(); exp_add(128, 2); exp_add(144, 2); poll_wait(360);
    chk_stream("R8 frame spans setup", 1);
    chk(mem[BASE+4] == 32'h7FFF_FFFF && mem[BASE+8] == 0, "R8 mid-frame statuses",
        mem[BASE+8], 0);

    // R11: run dropped mid-descriptor stops after write-back
    wdesc(0, 1, 1, 1, 0, 0, 2, 128);
    wdesc(1, 1, 1, 1, 0, 1, 2, 144);
    mark(); exp_add(128, 2);
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    repeat (3) @(negedge clk); tx_run = 1'b0;
    repeat (80) @(negedge clk);
    chk_stream("R11 current descriptor finished", 1);
    chk(mem[BASE+4] == 32'h8000_0000, "R11 next not taken", mem[BASE+4], 32'h8000_0000);
    chk(rd_cnt - rd0 == 4, "R11 no next fetch", 32'(rd_cnt - rd0), 4);
    tx_run = 1'b1;
    mark(); exp_add(144, 2); poll_wait(80);
    chk_stream("R11 resume at next index", 1);
    chk(mem[BASE+4] == 0 && rd_cnt - rd0 == 5, "R11 resumed status and reads",
        32'(rd_cnt - rd0), 5);

    done = 1'b1;
    $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
    $finish;
  end
endmodule